// File: doc/BRIEF.md
# SD Request Completion Sequencer

This block follows a single SD/MMC request from the moment its command is handed to the bus logic until the request can be reported finished. The bus logic reports progress as one-cycle event pulses: command sent, command timeout, data finished, data timeout, receive CRC error, transmit CRC error, and card interrupt. The sequencer turns them into a completion pulse with command and data error codes, a flag that the data transfer itself closed the request, and the number of bytes moved.

When a request is issued, the sequencer records whether it moves data, whether a response is expected and whether a stop command follows the data phase. A request with data completes only after both the command-sent and the data-finished events, which may arrive in either order or in the same cycle. If a stop command is attached, the sequencer issues it once by itself before it reports completion. A deselect command completes as soon as it is issued. Card interrupts are forwarded separately and never disturb the request in flight.

Top module: `sd_req_tracker`

## Requirements
- R1: On `req_issue` while idle, a request with `req_data`=1 waits for both command-sent and data-finish. One with `req_data`=0 and `req_rsp`=1 waits for the response only. Any other request waits for command-sent only. `req_issue` while a request is open is ignored.
- R2: `ev_ctmo` in any waiting state ends the request with `cmd_err`=1 (timeout). When the request carries data, it also sets `data_err`=1.
- R3: `ev_sent` ends a response-only or sent-only request. In the wait-for-both state it leaves the request open and waiting for data-finish only.
- R4: For a command without data, `ev_dfin`, `ev_dtmo`, `ev_rxcrc` and `ev_txcrc` have no effect.
- R5: `ev_rxcrc` or `ev_txcrc` ends a data request with `data_err`=2 (illegal sequence). `ev_dtmo` ends it with `data_err`=1 (timeout).
- R6: `ev_dfin` while waiting for data-finish only ends the request and sets `dma_complete`=1. In the wait-for-both state it leaves the request waiting for command-sent, and a later `ev_sent` ends the request with `dma_complete`=0.
- R7: Events that arrive while idle or in the cycle the request is being finalized are ignored.
- R8: `sdio_irq` is high for one cycle, one clock edge after each `ev_sdio`, in any state, and `ev_sdio` alone leaves the request state unchanged.
- R9: When a data request with `req_stop`=1 is finalized, `stop_req` pulses once instead of `done`. The stop command then waits for its response with no data, and its end raises `done`. `stop_req` fires at most once per request.
- R10: At `done`, `byte_count` equals `blk_cnt`×`blk_size` for a data request with `data_err`=0, and 0 otherwise. It holds until the next issue.
- R11: Issuing command index `DESEL_IDX` (7) with `cmd_arg`=0 raises `done` one clock edge after the issue edge, without waiting for events.
- R12: `done` is a single-cycle pulse, two clock edges after the ending event, after which the block is idle. Within one cycle the events rank: command timeout, then command-sent, then CRC error, then data timeout, then data-finish. A same-cycle command-sent and data-finish in the wait-for-both state ends the request with `dma_complete`=1. At reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_issue | input | 1 | Start a request (sampled when idle) |
| req_data | input | 1 | Request moves data |
| req_rsp | input | 1 | Command expects a response |
| req_stop | input | 1 | Stop command follows the data phase |
| cmd_index | input | IDX_W | Command index |
| cmd_arg | input | ARG_W | Command argument |
| blk_cnt | input | BCNT_W | Number of blocks |
| blk_size | input | BSIZE_W | Bytes per block |
| ev_sent | input | 1 | Command sent / response received |
| ev_ctmo | input | 1 | Command timeout |
| ev_dfin | input | 1 | Data transfer finished |
| ev_dtmo | input | 1 | Data timeout |
| ev_rxcrc | input | 1 | Receive CRC error |
| ev_txcrc | input | 1 | Transmit CRC error |
| ev_sdio | input | 1 | Card interrupt |
| done | output | 1 | Request finished (one-cycle pulse) |
| cmd_err | output | 2 | 0 none, 1 timeout |
| data_err | output | 2 | 0 none, 1 timeout, 2 illegal sequence |
| dma_complete | output | 1 | Data-finish closed the request |
| byte_count | output | BCNT_W+BSIZE_W | Bytes transferred |
| stop_req | output | 1 | Issue the stop command (one-cycle pulse) |
| sdio_irq | output | 1 | Forwarded card interrupt |

## Verification
An event is taken at the edge that ends its cycle, and the request is finalized at the following edge. So `done`, `stop_req` and the result fields are due two edges after the event, `sdio_irq` one edge after `ev_sdio`, and a deselect's `done` one edge after the issue edge. The bench drives each pulse on a falling edge for exactly one cycle. It samples on the falling edge that lies after the due rising edge, and checks on the next falling edge that the pulse has dropped. Where an event must be ignored, the bench looks on the falling edge where a reaction would have appeared and finds `done` and `stop_req` low. It then finishes the request with a later event and checks the fields the ignored event could have changed.

// File: rtl/sd_req_tracker.sv
module sd_req_tracker #(
  parameter int BCNT_W    = 12,
  parameter int BSIZE_W   = 12,
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int DESEL_IDX = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_issue,
  input  logic                        req_data,
  input  logic                        req_rsp,
  input  logic                        req_stop,
  input  logic [IDX_W-1:0]            cmd_index,
  input  logic [ARG_W-1:0]            cmd_arg,
  input  logic [BCNT_W-1:0]           blk_cnt,
  input  logic [BSIZE_W-1:0]          blk_size,
  input  logic                        ev_sent,
  input  logic                        ev_ctmo,
  input  logic                        ev_dfin,
  input  logic                        ev_dtmo,
  input  logic                        ev_rxcrc,
  input  logic                        ev_txcrc,
  input  logic                        ev_sdio,
  output logic                        done,
  output logic [1:0]                  cmd_err,
  output logic [1:0]                  data_err,
  output logic                        dma_complete,
  output logic [BCNT_W+BSIZE_W-1:0]   byte_count,
  output logic                        stop_req,
  output logic                        sdio_irq
);
  localparam int CNT_W = BCNT_W + BSIZE_W;

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_BOTH = 3'd1;
  localparam logic [2:0] S_XFER = 3'd2;
  localparam logic [2:0] S_RSP  = 3'd3;
  localparam logic [2:0] S_SENT = 3'd4;
  localparam logic [2:0] S_FIN  = 3'd5;

  localparam logic [1:0] E_NONE  = 2'd0;
  localparam logic [1:0] E_TMO   = 2'd1;
  localparam logic [1:0] E_ILSEQ = 2'd2;

  logic [2:0]         st;
  logic               ph_data;
  logic               rq_data;
  logic               rq_stop;
  logic               stop_sent;
  logic [BCNT_W-1:0]  bc_q;
  logic [BSIZE_W-1:0] bs_q;

  logic       waiting;
  logic       desel;
  logic [2:0] st_a;
  logic       crc_hit;

  assign waiting = (st == S_BOTH) || (st == S_XFER) || (st == S_RSP) || (st == S_SENT);
  assign desel   = (cmd_index == IDX_W'(DESEL_IDX)) && (cmd_arg == '0);
  assign st_a    = (ev_sent && st == S_BOTH) ? S_XFER : st;
  assign crc_hit = ev_rxcrc || ev_txcrc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ph_data      <= 1'b0;
      rq_data      <= 1'b0;
      rq_stop      <= 1'b0;
      stop_sent    <= 1'b0;
      bc_q         <= '0;
      bs_q         <= '0;
      done         <= 1'b0;
      stop_req     <= 1'b0;
      sdio_irq     <= 1'b0;
      cmd_err      <= E_NONE;
      data_err     <= E_NONE;
      dma_complete <= 1'b0;
      byte_count   <= '0;
    end else begin
      done     <= 1'b0;
      stop_req <= 1'b0;
      sdio_irq <= ev_sdio;
      if (st == S_IDLE) begin
        if (req_issue) begin
          ph_data      <= req_data && !desel;
          rq_data      <= req_data && !desel;
          rq_stop      <= req_stop;
          stop_sent    <= 1'b0;
          bc_q         <= blk_cnt;
          bs_q         <= blk_size;
          cmd_err      <= E_NONE;
          data_err     <= E_NONE;
          dma_complete <= 1'b0;
          byte_count   <= '0;
          if (desel)         st <= S_FIN;
          else if (req_data) st <= S_BOTH;
          else if (req_rsp)  st <= S_RSP;
          else               st <= S_SENT;
        end
      end else if (waiting) begin
        if (ev_ctmo) begin
          cmd_err <= E_TMO;
          if (ph_data) data_err <= E_TMO;
          st <= S_FIN;
        end else if (ev_sent && (st == S_RSP || st == S_SENT)) begin
          st <= S_FIN;
        end else if (!ph_data) begin
          st <= st_a;
        end else if (crc_hit) begin
          data_err <= E_ILSEQ;
          st <= S_FIN;
        end else if (ev_dtmo) begin
          data_err <= E_TMO;
          st <= S_FIN;
        end else if (ev_dfin && st_a == S_XFER) begin
          dma_complete <= 1'b1;
          st <= S_FIN;
        end else if (ev_dfin && st_a == S_BOTH) begin
          st <= S_RSP;
        end else begin
          st <= st_a;
        end
      end else if (st == S_FIN) begin
        if (rq_data && rq_stop && !stop_sent) begin
          stop_sent <= 1'b1;
          stop_req  <= 1'b1;
          ph_data   <= 1'b0;
          st        <= S_RSP;
        end else begin
          done <= 1'b1;
          if (rq_data && data_err == E_NONE)
            byte_count <= CNT_W'(bc_q) * CNT_W'(bs_q);
          else
            byte_count <= '0;
          st <= S_IDLE;
        end
      end else begin
        st <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/sd_req_tracker_chk.sv
module sd_req_tracker_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       st,
  input logic             req_issue,
  input logic             ev_sent,
  input logic             ev_ctmo,
  input logic             ev_dfin,
  input logic             ev_dtmo,
  input logic             ev_rxcrc,
  input logic             ev_txcrc,
  input logic             ev_sdio,
  input logic             done,
  input logic             stop_req,
  input logic             sdio_irq,
  input logic [1:0]       cmd_err,
  input logic [1:0]       data_err,
  input logic             dma_complete,
  input logic [CNT_W-1:0] byte_count
);
  logic [1:0] stop_cnt;
  logic       waiting;
  logic       other_ev;

  assign waiting  = (st >= 3'd1) && (st <= 3'd4);
  assign other_ev = ev_sent || ev_ctmo || ev_dfin || ev_dtmo || ev_rxcrc || ev_txcrc;

  always_ff @(posedge clk) begin
    if (!rst_n) stop_cnt <= 2'd0;
    else if (req_issue && st == 3'd0) stop_cnt <= 2'd0;
    else if (stop_req && stop_cnt != 2'd2) stop_cnt <= stop_cnt + 2'd1;
  end

  p_ctmo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && ev_ctmo) |=> (st == 3'd5 && cmd_err == 2'd1));

  p_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_complete) |-> $past(ev_dfin));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !req_issue) |=> (st == 3'd0));

  p_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |=> (done || stop_req));

  p_sdio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sdio |=> sdio_irq);

  p_sdio_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && ev_sdio && !other_ev) |=> (st == $past(st)));

  p_stop_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cnt <= 2'd1);

  p_bytes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && data_err != 2'd0) |-> (byte_count == '0));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && stop_req));
endmodule

bind sd_req_tracker sd_req_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .req_issue(req_issue),
  .ev_sent(ev_sent), .ev_ctmo(ev_ctmo), .ev_dfin(ev_dfin), .ev_dtmo(ev_dtmo),
  .ev_rxcrc(ev_rxcrc), .ev_txcrc(ev_txcrc), .ev_sdio(ev_sdio),
  .done(done), .stop_req(stop_req), .sdio_irq(sdio_irq),
  .cmd_err(cmd_err), .data_err(data_err), .dma_complete(dma_complete),
  .byte_count(byte_count)
);

// File: tb/tb_sd_req_tracker.sv
`timescale 1ns/1ps
module tb_sd_req_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_issue = 0, req_data = 0, req_rsp = 0, req_stop = 0;
  logic [5:0]  cmd_index = 6'd0;
  logic [31:0] cmd_arg = 32'd0;
  logic [11:0] blk_cnt = 12'd0, blk_size = 12'd0;
  logic ev_sent = 0, ev_ctmo = 0, ev_dfin = 0, ev_dtmo = 0;
  logic ev_rxcrc = 0, ev_txcrc = 0, ev_sdio = 0;
  logic done, dma_complete, stop_req, sdio_irq;
  logic [1:0] cmd_err, data_err;
  logic [23:0] byte_count;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sd_req_tracker dut (
    .clk(clk), .rst_n(rst_n), .req_issue(req_issue), .req_data(req_data),
    .req_rsp(req_rsp), .req_stop(req_stop), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .blk_cnt(blk_cnt), .blk_size(blk_size), .ev_sent(ev_sent), .ev_ctmo(ev_ctmo),
    .ev_dfin(ev_dfin), .ev_dtmo(ev_dtmo), .ev_rxcrc(ev_rxcrc), .ev_txcrc(ev_txcrc),
    .ev_sdio(ev_sdio), .done(done), .cmd_err(cmd_err), .data_err(data_err),
    .dma_complete(dma_complete), .byte_count(byte_count), .stop_req(stop_req),
    .sdio_irq(sdio_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic d, input logic r, input logic s, input logic [5:0] idx,
                       input logic [31:0] arg, input logic [11:0] bc, input logic [11:0] bs);
    req_issue = 1; req_data = d; req_rsp = r; req_stop = s;
    cmd_index = idx; cmd_arg = arg; blk_cnt = bc; blk_size = bs;
    @(negedge clk);
    req_issue = 0; req_data = 0; req_rsp = 0; req_stop = 0;
  endtask

  task automatic pulse(input logic s, input logic c, input logic f, input logic t,
                       input logic rx, input logic tx, input logic io);
    ev_sent = s; ev_ctmo = c; ev_dfin = f; ev_dtmo = t;
    ev_rxcrc = rx; ev_txcrc = tx; ev_sdio = io;
    @(negedge clk);
    ev_sent = 0; ev_ctmo = 0; ev_dfin = 0; ev_dtmo = 0;
    ev_rxcrc = 0; ev_txcrc = 0; ev_sdio = 0;
  endtask

  task automatic expect_done(input string tag, input logic [1:0] ce, input logic [1:0] de,
                             input logic dm, input logic [23:0] bytes);
    @(negedge clk);
    chk({tag, " done"}, done, 1);
    chk({tag, " stop_req"}, stop_req, 0);
    chk({tag, " cmd_err"}, cmd_err, ce);
    chk({tag, " data_err"}, data_err, de);
    chk({tag, " dma_complete"}, dma_complete, dm);
    chk({tag, " byte_count"}, byte_count, bytes);
    @(negedge clk);
    chk({tag, " done pulse end"}, done, 0);
  endtask

  task automatic expect_quiet(input string tag);
    @(negedge clk);
    chk({tag, " done"}, done, 0);
    chk({tag, " stop_req"}, stop_req, 0);
  endtask

  task automatic t_reset;
    chk("R12 reset done", done, 0);
    chk("R12 reset cmd_err", cmd_err, 0);
    chk("R12 reset data_err", data_err, 0);
    chk("R12 reset byte_count", byte_count, 0);
    chk("R12 reset stop_req", stop_req, 0);
    chk("R12 reset sdio_irq", sdio_irq, 0);
  endtask

  task automatic t_sent_only;
    issue(0, 0, 0, 6'd0, 32'd0, 12'd0, 12'd0);
    pulse(1, 0, 0, 0, 0, 0, 0);
    expect_done("R1 R3 sent-only", 0, 0, 0, 0);
  endtask

  task automatic t_rsp_only;
    issue(0, 1, 0, 6'd13, 32'd1, 12'd4, 12'd64);
    pulse(0, 0, 1, 1, 1, 1, 0);
    expect_quiet("R4 data events on no-data command");
    pulse(1, 0, 0, 0, 0, 0, 0);
    expect_done("R4 rsp-only after ignored data events", 0, 0, 0, 0);
  endtask

  task automatic t_sent_then_dfin;
    issue(1, 1, 0, 6'd17, 32'd0, 12'd3, 12'd512);
    pulse(1, 0, 0, 0, 0, 0, 0);
    expect_quiet("R3 sent in wait-both keeps open");
    pulse(0, 0, 1, 0, 0, 0, 0);
    expect_done("R6 R10 sent then dfin", 0, 0, 1, 24'd1536);
  endtask

  task automatic t_dfin_then_sent;
    issue(1, 1, 0, 6'd18, 32'd0, 12'd2, 12'd100);
    pulse(0, 0, 1, 0, 0, 0, 0);
    expect_quiet("R6 dfin in wait-both keeps open");
    pulse(1, 0, 0, 0, 0, 0, 0);
    expect_done("R6 dfin then sent", 0, 0, 0, 24'd200);
  endtask

  task automatic t_same_cycle;
    issue(1, 1, 0, 6'd18, 32'd0, 12'd5, 12'd8);
    pulse(1, 0, 1, 0, 0, 0, 0);
    expect_done("R12 sent and dfin same cycle", 0, 0, 1, 24'd40);
  endtask

  task automatic t_ctmo;
    issue(1, 1, 0, 6'd17, 32'd0, 12'd1, 12'd512);
    pulse(0, 1, 0, 0, 0, 0, 0);
    expect_done("R2 command timeout with data", 1, 1, 0, 0);
    issue(0, 1, 0, 6'd8, 32'd0, 12'd0, 12'd0);
    pulse(1, 1, 0, 0, 0, 0, 0);
    expect_done("R2 R12 timeout beats sent", 1, 0, 0, 0);
  endtask

  task automatic t_data_errors;
    issue(1, 1, 0, 6'd17, 32'd0, 12'd1, 12'd512);
    pulse(0, 0, 0, 0, 1, 0, 0);
    expect_done("R5 rx crc", 0, 2, 0, 0);
    issue(1, 1, 0, 6'd24, 32'd0, 12'd1, 12'd512);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1, 0);
    expect_done("R5 tx crc", 0, 2, 0, 0);
    issue(1, 1, 0, 6'd17, 32'd0, 12'd1, 12'd512);
    pulse(0, 0, 0, 1, 0, 0, 0);
    expect_done("R5 data timeout", 0, 1, 0, 0);
    issue(1, 1, 0, 6'd17, 32'd0, 12'd1, 12'd512);
    pulse(0, 0, 1, 1, 1, 0, 0);
    expect_done("R12 crc beats timeout and dfin", 0, 2, 0, 0);
  endtask

  task automatic t_stop;
    issue(1, 1, 1, 6'd18, 32'd0, 12'd4, 12'd512);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 stop_req pulse", stop_req, 1);
    chk("R9 no done at stop", done, 0);
    pulse(0, 0, 1, 0, 0, 0, 0);
    chk("R9 stop_req single", stop_req, 0);
    expect_quiet("R9 stop waits for response");
    pulse(1, 0, 0, 0, 0, 0, 0);
    expect_done("R9 R10 stop completion", 0, 0, 1, 24'd2048);
    expect_quiet("R9 no second stop");
  endtask

  task automatic t_deselect;
    issue(0, 1, 0, 6'd7, 32'd0, 12'd0, 12'd0);
    expect_done("R11 deselect immediate", 0, 0, 0, 0);
    issue(0, 1, 0, 6'd7, 32'd5, 12'd0, 12'd0);
    expect_quiet("R11 select with nonzero arg waits");
    pulse(1, 0, 0, 0, 0, 0, 0);
    expect_done("R11 select completes on sent", 0, 0, 0, 0);
  endtask

  task automatic t_sdio;
    pulse(0, 0, 0, 0, 0, 0, 1);
    chk("R8 sdio forwarded idle", sdio_irq, 1);
    @(negedge clk);
    chk("R8 sdio one cycle", sdio_irq, 0);
    chk("R8 sdio no done", done, 0);
    issue(1, 1, 0, 6'd17, 32'd0, 12'd2, 12'd16);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 0, 1);
    chk("R8 sdio forwarded busy", sdio_irq, 1);
    chk("R8 sdio no done busy", done, 0);
    pulse(0, 0, 1, 0, 0, 0, 0);
    expect_done("R8 request intact after sdio", 0, 0, 1, 24'd32);
  endtask

  task automatic t_ignore;
    pulse(1, 1, 1, 1, 1, 1, 0);
    expect_quiet("R7 events while idle");
    chk("R7 idle cmd_err held", cmd_err, 0);
    chk("R7 idle byte_count held", byte_count, 24'd32);
    issue(0, 1, 0, 6'd13, 32'd0, 12'd0, 12'd0);
    issue(1, 1, 0, 6'd17, 32'd0, 12'd9, 12'd9);
    pulse(1, 0, 0, 0, 0, 0, 0);
    ev_ctmo = 1; ev_dtmo = 1;
    @(negedge clk);
    ev_ctmo = 0; ev_dtmo = 0;
    chk("R7 done while finalizing", done, 1);
    chk("R7 finalizing cmd_err", cmd_err, 0);
    chk("R1 busy issue ignored byte_count", byte_count, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sent_only();
    t_rsp_only();
    t_sent_then_dfin();
    t_dfin_then_sent();
    t_same_cycle();
    t_ctmo();
    t_data_errors();
    t_stop();
    t_deselect();
    t_sdio();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule